// File: doc/BRIEF.md
# SDRAM Column Burst Engine with Clock Suspend

This block is the column-sequencing core of a synchronous DRAM device model. Each READ or WRITE command that is registered on an active edge carries a starting column. From that column the engine walks the column address through a burst whose length and ordering come from mode inputs. For every beat it drives the current column together with a read-data-valid strobe or a write-accept strobe.

A clock-enable input can stall the engine. A low sample on a rising edge suspends the next internal edge. On that edge the burst counter holds, any command or write beat is discarded, and read data that is already being driven stays on the outputs. A single-write mode limits every WRITE to one column and leaves READs at the programmed length. Length, ordering and single-write mode are captured when a command is accepted, so they stay fixed for the whole of that burst.

Top module: `sdram_burst_engine`

## Requirements
- R1: While rst_ni is low, rd_valid_o and wr_accept_o are 0.
- R2: A READ accepted on an active edge raises rd_valid_o for the next N active cycles, where N = 2^bl_sel_i (bl_sel_i 0..3 gives 1, 2, 4 or 8). The first beat shows the start column. The engine is idle afterwards.
- R3: With ilv_i = 0, beat k drives column (start & ~(N-1)) | ((start + k) & (N-1)). The column wraps inside the aligned N-column block, and the bits above the block stay unchanged.
- R4: With ilv_i = 1, beat k drives column start XOR k.
- R5: With wr_single_i = 1, a WRITE produces exactly one write-accept beat at the start column, whatever bl_sel_i is.
- R6: With wr_single_i = 1, a READ still runs the full N beats in the selected ordering.
- R7: When cke_i is sampled low on an edge, the following edge is suspended. On that edge the burst index does not advance, so col_o and rd_valid_o keep their values for one extra cycle.
- R8: A READ or WRITE command presented on a suspended edge is ignored. It neither starts nor truncates a burst.
- R9: wr_accept_o is 0 in any cycle whose closing edge is suspended. The write beat at that column is offered again in the next cycle, so no column is skipped.
- R10: A command on an active edge truncates any burst in progress and restarts the burst at its own start column.
- R11: With bl_sel_i = 0, every burst is a single beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable; a low sample suspends the next internal edge |
| cmd_valid_i | input | 1 | A READ or WRITE command is present |
| cmd_write_i | input | 1 | 1 = WRITE, 0 = READ |
| col_i | input | COL_W | Starting column of the command |
| bl_sel_i | input | BLS_W | Burst length select, length = 2^bl_sel_i |
| ilv_i | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| wr_single_i | input | 1 | 1 = each WRITE is a single column |
| col_o | output | COL_W | Column of the current beat |
| rd_valid_o | output | 1 | A read beat is being driven |
| wr_accept_o | output | 1 | The write beat is taken at the coming edge |

## Verification
A burst index that is off by one shows up on col_o in the very next cycle as a wrong column. A wrong length shows up at the tail of the burst, where a strobe either stays high for one cycle too many or drops one cycle early. Faulty suspend handling shows up exactly one cycle after a low cke_i sample: a column advances when it should repeat, or a write accept that should be withheld is asserted. A command that is wrongly let through on a suspended edge shows up as a burst that starts one cycle later.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} ord_e;

  function automatic int unsigned clamp_sel(input int unsigned sel, input int unsigned max_sel);
    return (sel > max_sel) ? max_sel : sel;
  endfunction
endpackage

// File: rtl/sbe_suspend_gate.sv
module sbe_suspend_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic sus_o,
  output logic step_o
);
  logic sus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sus_q <= 1'b0;
    else         sus_q <= ~cke_i;
  end

  assign sus_o  = sus_q;
  assign step_o = ~sus_q;
endmodule

// File: rtl/sbe_burst_ctrl.sv
module sbe_burst_ctrl #(
  parameter int unsigned COL_W = 9,
  parameter int unsigned IDX_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               cmd_valid_i,
  input  logic               cmd_write_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [IDX_W-1:0]   len_m1_i,
  input  sbe_pkg::ord_e      ord_i,
  output logic               active_o,
  output logic               write_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [COL_W-1:0]   start_o,
  output logic [IDX_W-1:0]   len_m1_o,
  output sbe_pkg::ord_e      ord_o
);
  logic             active_q, write_q;
  logic [IDX_W-1:0] idx_q, len_m1_q;
  logic [COL_W-1:0] start_q;
  sbe_pkg::ord_e    ord_q;
  logic             last_beat;

  assign last_beat = (idx_q == len_m1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      idx_q    <= '0;
      len_m1_q <= '0;
      start_q  <= '0;
      ord_q    <= sbe_pkg::ORD_SEQ;
    end else if (step_i) begin
      if (cmd_valid_i) begin
        // new command restarts the burst
        active_q <= 1'b1;
        write_q  <= cmd_write_i;
        idx_q    <= '0;
        len_m1_q <= len_m1_i;
        start_q  <= col_i;
        ord_q    <= ord_i;
      end else if (active_q) begin
        if (last_beat) begin
          active_q <= 1'b0;
          idx_q    <= '0;
        end else begin
          idx_q    <= idx_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign write_o  = write_q;
  assign idx_o    = idx_q;
  assign start_o  = start_q;
  assign len_m1_o = len_m1_q;
  assign ord_o    = ord_q;
endmodule

// File: rtl/sbe_col_gen.sv
module sbe_col_gen #(
  parameter int unsigned COL_W = 9,
  parameter int unsigned IDX_W = 3
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] len_m1_i,
  input  sbe_pkg::ord_e    ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [IDX_W-1:0] seq_sum;

  assign seq_sum = start_i[IDX_W-1:0] + idx_i;

  // bits inside the burst block follow the ordering, the rest pass through
  for (genvar b = 0; b < IDX_W; b++) begin : g_low
    logic moved;
    assign moved    = (ord_i == sbe_pkg::ORD_ILV) ? (start_i[b] ^ idx_i[b]) : seq_sum[b];
    assign col_o[b] = len_m1_i[b] ? moved : start_i[b];
  end

  if (COL_W > IDX_W) begin : g_high
    assign col_o[COL_W-1:IDX_W] = start_i[COL_W-1:IDX_W];
  end
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine #(
  parameter int unsigned COL_W  = 9,
  parameter int unsigned MAX_BL = 8,
  localparam int unsigned IDX_W = (MAX_BL > 1) ? $clog2(MAX_BL) : 1,
  localparam int unsigned BLS_W = $clog2(IDX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [BLS_W-1:0] bl_sel_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  output logic [COL_W-1:0] col_o,
  output logic             rd_valid_o,
  output logic             wr_accept_o
);
  logic             sus_q, step;
  logic             active, write;
  logic [IDX_W-1:0] idx, len_m1, cur_len_m1, bl_len_m1;
  logic [COL_W-1:0] start;
  sbe_pkg::ord_e    ord, cmd_ord;

  always_comb begin
    bl_len_m1 = '0;
    for (int unsigned s = 0; s <= IDX_W; s++) begin
      if (s == sbe_pkg::clamp_sel(32'(bl_sel_i), IDX_W))
        bl_len_m1 = IDX_W'((1 << s) - 1);
    end
  end

  assign cur_len_m1 = (cmd_write_i && wr_single_i) ? '0 : bl_len_m1;
  assign cmd_ord    = ilv_i ? sbe_pkg::ORD_ILV : sbe_pkg::ORD_SEQ;

  sbe_suspend_gate i_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_i  (cke_i),
    .sus_o  (sus_q),
    .step_o (step)
  );

  sbe_burst_ctrl #(.COL_W(COL_W), .IDX_W(IDX_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .cmd_valid_i (cmd_valid_i),
    .cmd_write_i (cmd_write_i),
    .col_i       (col_i),
    .len_m1_i    (cur_len_m1),
    .ord_i       (cmd_ord),
    .active_o    (active),
    .write_o     (write),
    .idx_o       (idx),
    .start_o     (start),
    .len_m1_o    (len_m1),
    .ord_o       (ord)
  );

  sbe_col_gen #(.COL_W(COL_W), .IDX_W(IDX_W)) i_col (
    .start_i  (start),
    .idx_i    (idx),
    .len_m1_i (len_m1),
    .ord_i    (ord),
    .col_o    (col_o)
  );

  assign rd_valid_o  = active & ~write;
  assign wr_accept_o = active & write & ~sus_q;
endmodule

// File: rtl/sbe_checker.sv
module sbe_checker #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cke_i,
  input logic             cmd_valid_i,
  input logic             cmd_write_i,
  input logic [COL_W-1:0] col_i,
  input logic             wr_single_i,
  input logic             sus_i,
  input logic [COL_W-1:0] col_o,
  input logic             rd_valid_o,
  input logic             wr_accept_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!rd_valid_o && !wr_accept_o); // R1
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_accept_o)); // R2

  AST_SUSPEND_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> ##2 ($stable(col_o) && $stable(rd_valid_o))); // R7

  AST_NO_ACCEPT_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> !wr_accept_o); // R9

  AST_RESTART_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sus_i && cmd_valid_i && !cmd_write_i) |=> (rd_valid_o && col_o == $past(col_i))); // R10

  AST_SINGLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sus_i && cke_i && cmd_valid_i && cmd_write_i && wr_single_i) ##1 !cmd_valid_i
    |=> (!wr_accept_o && !rd_valid_o)); // R5
endmodule

bind sdram_burst_engine sbe_checker #(.COL_W(COL_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_i       (cke_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_write_i (cmd_write_i),
  .col_i       (col_i),
  .wr_single_i (wr_single_i),
  .sus_i       (sus_q),
  .col_o       (col_o),
  .rd_valid_o  (rd_valid_o),
  .wr_accept_o (wr_accept_o)
);

// File: tb/test_sdram_burst_engine.sv
`timescale 1ns/1ps
module test_sdram_burst_engine;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cke = 1'b1;
  logic             cv = 1'b0, cw = 1'b0;
  logic [COL_W-1:0] col = '0;
  logic [1:0]       bl = 2'd0;
  logic             ilv = 1'b0, single = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             rd_o, wa_o;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int               due;
    logic             rd;
    logic             wa;
    logic             act;
    logic [COL_W-1:0] col;
    string            tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  // reference state
  bit m_sus = 0, m_act = 0, m_wr = 0, m_ilv = 0;
  int m_k = 0, m_n = 1, m_st = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_burst_engine i_sdram_burst_engine (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cmd_valid_i(cv), .cmd_write_i(cw),
    .col_i(col), .bl_sel_i(bl), .ilv_i(ilv), .wr_single_i(single),
    .col_o(col_o), .rd_valid_o(rd_o), .wr_accept_o(wa_o)
  );

  function automatic int exp_col(int st, int k, int n, bit il);
    if (il) return (st ^ k) & ((1 << COL_W) - 1);
    return ((st & ~(n - 1)) | ((st + k) & (n - 1))) & ((1 << COL_W) - 1);
  endfunction

  task automatic step(input bit v, input bit w, input int c, input bit ck, input string tag);
    exp_t x;
    @(posedge clk); #1;
    cv = v; cw = w; col = COL_W'(c); cke = ck;
    if (!m_sus) begin
      if (v) begin
        m_act = 1; m_wr = w; m_k = 0; m_st = c; m_ilv = ilv;
        m_n = (w && single) ? 1 : (1 << bl);
      end else if (m_act) begin
        m_k++;
        if (m_k == m_n) m_act = 0;
      end
    end
    m_sus = !ck;
    x.due = cyc + 1;
    x.act = m_act;
    x.rd  = m_act && !m_wr;
    x.wa  = m_act && m_wr && !m_sus;
    x.col = COL_W'(exp_col(m_st, m_k, m_n, m_ilv));
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        vectors++;
        if (rd_o !== e.rd || wa_o !== e.wa || (e.act && col_o !== e.col)) begin
          fails++;
          $display("FAIL %s: rd=%b wa=%b col=%h expected rd=%b wa=%b col=%h (act=%b)",
                   e.tag, rd_o, wa_o, col_o, e.rd, e.wa, e.col, e.act);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (rd_o !== 1'b0 || wa_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: rd=%b wa=%b expected rd=0 wa=0", rd_o, wa_o);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 / R3: length 4 sequential, wrap inside block
    bl = 2; ilv = 0; single = 0;
    step(1, 0, 'h15, 1, "R2"); idle(5, "R2");
    bl = 3;
    step(1, 0, 'h11e, 1, "R3"); idle(9, "R3");
    bl = 1;
    step(1, 0, 'h0f3, 1, "R3"); idle(3, "R3");

    // R4 interleaved
    bl = 3; ilv = 1;
    step(1, 0, 'h0b, 1, "R4"); idle(9, "R4");
    bl = 2;
    step(1, 1, 'h1a6, 1, "R4"); idle(5, "R4");

    // R11 single beat
    bl = 0; ilv = 0;
    step(1, 0, 'h077, 1, "R11"); step(1, 1, 'h078, 1, "R11"); idle(3, "R11");

    // R5 / R6 single-write mode
    bl = 3; single = 1;
    step(1, 1, 'h043, 1, "R5"); idle(3, "R5");
    ilv = 1;
    step(1, 0, 'h043, 1, "R6"); idle(9, "R6");
    ilv = 0; single = 0;

    // R7 suspend during read
    bl = 2;
    step(1, 0, 'h020, 1, "R7"); step(0, 0, 0, 0, "R7"); idle(6, "R7");
    step(1, 0, 'h031, 1, "R7"); step(0, 0, 0, 0, "R7"); step(0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, "R7"); idle(6, "R7");

    // R8 command on suspended edge ignored
    step(0, 0, 0, 0, "R8"); step(1, 0, 'h055, 1, "R8"); idle(3, "R8");
    step(1, 0, 'h060, 0, "R8"); step(1, 1, 'h0a0, 1, "R8"); idle(6, "R8");

    // R9 write beat withheld under suspend
    step(1, 1, 'h088, 1, "R9"); step(0, 0, 0, 0, "R9"); step(0, 0, 0, 0, "R9");
    idle(6, "R9");

    // R10 truncation and restart
    bl = 3;
    step(1, 0, 'h100, 1, "R10"); idle(2, "R10");
    step(1, 0, 'h10d, 1, "R10"); idle(1, "R10");
    step(1, 1, 'h1f0, 1, "R10"); idle(9, "R10");

    repeat (3) @(posedge clk);
    vectors++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d expected beats unchecked, expected 0", q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2: watchdog expired, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule